// File: doc/BRIEF.md
# SMBus Host Transaction Register Engine

This block is the register-facing half of an SMBus host. Software programs a small window of byte-wide registers: target address with direction flag, command byte, two data bytes, a block-data byte and a control byte holding the transaction kind. It then sets a start bit. The engine breaks the chosen transaction into byte-level requests to a separate bus master, which handles the wire timing. It collects the acknowledge and arbitration results and finishes by raising a done flag or one of several error flags.

Block transfers carry up to a fixed maximum of bytes through the single block-data register. After every byte except the final one, the engine raises a byte-done flag and waits. During that pause software supplies the next outgoing byte or collects the incoming one. It then clears the flag, which lets the engine continue.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0 (offsets 0..7), `irq` is 0 and no request is issued.
- R2: Control type code 0 (bits 4:2 = 000) issues START(op 0), WRITE(op 1) of the address byte unchanged, STOP(op 4). Status bit0 (busy) is 1 while the transaction runs. Status bit1 (done) rises in the same cycle that busy falls.
- R3: Type code 1 (byte): a write (address bit0 = 0) sends the address byte, then the command byte. A read (bit0 = 1) sends the address byte, then READ_NACK(op 3), and stores the received byte in data0 (offset 5).
- R4: Type codes 2 (byte-data) and 3 (word). A write sends address with bit0 cleared, command, data0, then data1 for word. A read sends address with bit0 cleared and the command, then a repeated START and the address with bit0 set. It then reads one byte (byte-data) or two bytes (word, READ_ACK op 2 followed by READ_NACK). The first byte goes to data0 and the second to data1.
- R5: Type code 5 (block write). The byte count in data0 is clamped to 1..32 and written back to data0. The count byte is sent after the command, followed by the block-data bytes. Status bit7 (byte done) is raised after every byte except the last, with busy still 1. No request is issued until software writes 1 to bit7.
- R6: Block read. After the repeated START, the first byte read is the count. It is clamped to 1..32 and stored in data0. Each data byte lands in block-data (offset 7). Every data byte except the last is read with READ_ACK, and the last uses READ_NACK.
- R7: With the I2C-style block input high at start, a block write omits the count byte.
- R8: A missing acknowledge on any written byte stops the transaction with STOP. Status bit2 is then set, busy clears and done stays 0.
- R9: Arbitration loss on any response sets status bit3 and clears busy at once, with no further request.
- R10: A start while any status bit 4:0 is set, or with an unsupported type code (4, 6 or 7 in bits 4:2), issues no request and sets status bit4 (failed). A start is ignored entirely while the host enable input is low.
- R11: Status bits 7 and 4:1 are cleared by writing 1. Writing back the value just read from status leaves 0. Control reads back bits 5:2 and bit0, and bit6 (start) reads as 0.
- R12: `irq` is 1 exactly when status bit1 and control bit0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host enable; starts are ignored while low |
| i2c_block_mode | input | 1 | Block writes send no count byte when high at start |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| req_valid | output | 1 | Byte-level request valid |
| req_ready | input | 1 | Bus master accepts request |
| req_op | output | 3 | 0 START, 1 WRITE, 2 READ_ACK, 3 READ_NACK, 4 STOP |
| req_data | output | 8 | Byte to write |
| rsp_valid | input | 1 | Response valid |
| rsp_data | input | 8 | Byte read |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_arb_lost | input | 1 | Arbitration lost during the operation |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps every short transaction kind in both directions against a byte-level target model. The logged request stream shows whether the repeated-start and address-bit handling differs correctly between read and write. Block writes run with counts 0, 1, 2, 5, 32 and 40 to expose both clamp edges and the number of pauses. Block reads use target-supplied counts 0, 1, 4 and 50, which show whether the NACK moves to the true last byte. Address NACK, arbitration loss, an unsupported code, disabled host and starts over stale status each trigger one distinct flag or refusal.

// File: rtl/smb_host_regs.sv
module smb_host_regs #(
  parameter int MAX_BLK = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_en,
  input  logic       i2c_block_mode,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       req_valid,
  input  logic       req_ready,
  output logic [2:0] req_op,
  output logic [7:0] req_data,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  input  logic       rsp_ack,
  input  logic       rsp_arb_lost,
  output logic       irq
);
  localparam int CW = $clog2(MAX_BLK + 1);
  localparam logic [2:0] OP_START = 3'd0, OP_WRITE = 3'd1, OP_RDA = 3'd2,
                         OP_RDN = 3'd3, OP_STOP = 3'd4;
  localparam logic [2:0] K_QUICK = 3'd0, K_BYTE = 3'd1, K_WORD = 3'd3, K_BLOCK = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_PAUSE} st_t;
  typedef enum logic [2:0] {PH_START, PH_ADDR, PH_CMD, PH_CNTW, PH_CNTR, PH_DATA, PH_STOP} ph_t;

  st_t st;
  ph_t ph;
  logic [3:0] ctl_type;
  logic ie, second, i2c_q, dev_pend;
  logic [7:0] cmd_r, adr_r, d0, d1, blk;
  logic f_done, f_dev, f_coll, f_fail, f_bdone;
  logic [CW-1:0] idx, len;

  function automatic logic [CW-1:0] clampc(input logic [7:0] v);
    if (v == 8'd0) return CW'(1);
    else if (int'(v) > MAX_BLK) return CW'(MAX_BLK);
    else return CW'(v);
  endfunction

  wire [2:0] ktype   = ctl_type[2:0];
  wire       rd      = adr_r[0];
  wire       is_blk  = ktype == K_BLOCK;
  wire       busy    = st != S_IDLE;
  wire       last_dt = idx == len - CW'(1);
  wire [7:0] sts_v   = {f_bdone, 2'b00, f_fail, f_coll, f_dev, f_done, busy};

  wire       wr_sts    = reg_wr && reg_addr == 3'd0;
  wire [2:0] nk        = reg_wdata[4:2];
  wire       start_req = reg_wr && reg_addr == 3'd2 && reg_wdata[6] && host_en && !busy;
  wire       start_ok  = start_req && sts_v[4:0] == 5'd0 && nk != 3'd4 && nk < 3'd6;

  assign req_valid = st == S_REQ;
  assign irq = f_done & ie;

  always_comb begin
    req_op = OP_WRITE;
    req_data = 8'h00;
    case (ph)
      PH_START: req_op = OP_START;
      PH_STOP:  req_op = OP_STOP;
      PH_ADDR:  req_data = second ? {adr_r[7:1], 1'b1} :
                (ktype == K_QUICK || ktype == K_BYTE) ? adr_r : {adr_r[7:1], 1'b0};
      PH_CMD:   req_data = cmd_r;
      PH_CNTW:  req_data = 8'(len);
      PH_CNTR:  req_op = OP_RDA;
      PH_DATA: begin
        if (rd) req_op = last_dt ? OP_RDN : OP_RDA;
        req_data = is_blk ? blk : (ktype == K_WORD && idx == CW'(1)) ? d1 : d0;
      end
      default: req_op = OP_STOP;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = sts_v;
      3'd2: reg_rdata = {2'b00, ctl_type, 1'b0, ie};
      3'd3: reg_rdata = cmd_r;
      3'd4: reg_rdata = adr_r;
      3'd5: reg_rdata = d0;
      3'd6: reg_rdata = d1;
      3'd7: reg_rdata = blk;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_START; ctl_type <= '0; ie <= 1'b0;
      second <= 1'b0; i2c_q <= 1'b0; dev_pend <= 1'b0;
      cmd_r <= '0; adr_r <= '0; d0 <= '0; d1 <= '0; blk <= '0;
      f_done <= 1'b0; f_dev <= 1'b0; f_coll <= 1'b0; f_fail <= 1'b0; f_bdone <= 1'b0;
      idx <= '0; len <= '0;
    end else begin
      if (wr_sts) begin
        if (reg_wdata[1]) f_done <= 1'b0;
        if (reg_wdata[2]) f_dev <= 1'b0;
        if (reg_wdata[3]) f_coll <= 1'b0;
        if (reg_wdata[4]) f_fail <= 1'b0;
        if (reg_wdata[7]) f_bdone <= 1'b0;
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd2: begin ctl_type <= reg_wdata[5:2]; ie <= reg_wdata[0]; end
          3'd3: cmd_r <= reg_wdata;
          3'd4: adr_r <= reg_wdata;
          3'd5: d0 <= reg_wdata;
          3'd6: d1 <= reg_wdata;
          3'd7: blk <= reg_wdata;
          default: ;
        endcase
      end
      if (start_req && !start_ok) f_fail <= 1'b1;
      if (start_ok) begin
        st <= S_REQ; ph <= PH_START; second <= 1'b0; idx <= '0;
        i2c_q <= i2c_block_mode; dev_pend <= 1'b0;
        if (nk == K_BLOCK) begin
          len <= clampc(d0);
          if (!rd) d0 <= 8'(clampc(d0));
        end else len <= (nk == K_WORD) ? CW'(2) : CW'(1);
      end
      case (st)
        S_REQ: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_arb_lost) begin
            f_coll <= 1'b1;
            st <= S_IDLE;
          end else begin
            st <= S_REQ;
            case (ph)
              PH_START: ph <= PH_ADDR;
              PH_ADDR:
                if (!rsp_ack) begin dev_pend <= 1'b1; ph <= PH_STOP; end
                else if (ktype == K_QUICK) ph <= PH_STOP;
                else if (second || (ktype == K_BYTE && rd)) ph <= is_blk ? PH_CNTR : PH_DATA;
                else ph <= PH_CMD;
              PH_CMD:
                if (!rsp_ack) begin dev_pend <= 1'b1; ph <= PH_STOP; end
                else if (ktype == K_BYTE) ph <= PH_STOP;
                else if (rd) begin second <= 1'b1; ph <= PH_START; end
                else if (is_blk && !i2c_q) ph <= PH_CNTW;
                else ph <= PH_DATA;
              PH_CNTW:
                if (!rsp_ack) begin dev_pend <= 1'b1; ph <= PH_STOP; end
                else ph <= PH_DATA;
              PH_CNTR: begin
                len <= clampc(rsp_data);
                d0 <= 8'(clampc(rsp_data));
                ph <= PH_DATA;
              end
              PH_DATA:
                if (!rd && !rsp_ack) begin dev_pend <= 1'b1; ph <= PH_STOP; end
                else begin
                  if (rd) begin
                    if (is_blk) blk <= rsp_data;
                    else if (ktype == K_WORD && idx == CW'(1)) d1 <= rsp_data;
                    else d0 <= rsp_data;
                  end
                  if (last_dt) ph <= PH_STOP;
                  else begin
                    idx <= idx + CW'(1);
                    if (is_blk) begin st <= S_PAUSE; f_bdone <= 1'b1; end
                  end
                end
              default: begin
                st <= S_IDLE;
                if (dev_pend) f_dev <= 1'b1;
                else f_done <= 1'b1;
              end
            endcase
          end
        end
        S_PAUSE: if (wr_sts && reg_wdata[7]) st <= S_REQ;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sts,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic [7:0] req_data,
  input logic       irq
);
  a_r2_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> $fell(sts[0]));
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_data));
  a_r5_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sts[7] && sts[0] |-> !req_valid);
  a_r8_dev_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> !sts[0] && !sts[1]);
  a_r9_coll_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[3]) |-> !sts[0]);
  a_r10_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(sts[4:1]) == 4'd0);
  a_r12_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts[1]);
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sts(sts_v), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_data(req_data), .irq(irq)
);

// File: tb/test_smb_host_regs.sv
`timescale 1ns/1ps
module test_smb_host_regs;
  logic clk = 0, rst_n = 0, host_en = 1, i2c_mode = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic req_valid, req_ready, rsp_valid = 0, rsp_ack = 0, rsp_arb = 0, irq;
  logic [2:0] req_op;
  logic [7:0] req_data, rsp_data = 0;

  assign req_ready = 1'b1;
  always #2 clk = ~clk;

  smb_host_regs i_smb_host_regs (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .i2c_block_mode(i2c_mode),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ack(rsp_ack), .rsp_arb_lost(rsp_arb),
    .irq(irq));

  localparam logic [6:0] TGT = 7'h2A;
  int checks = 0, fails = 0;
  logic [2:0] lop [0:127];
  logic [7:0] ldat [0:127];
  logic [2:0] eop [0:127];
  logic [7:0] edat [0:127];
  int nlog = 0, nexp = 0, nrsp = 0, rdk = 0, arb_n = -1;
  bit first_w = 0, cnt_mode = 0;
  logic [7:0] blk_cnt = 0, rd_base = 0;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (rst_n && req_valid) begin
      if (nlog < 128) begin lop[nlog] = req_op; ldat[nlog] = req_data; nlog++; end
      rsp_valid <= 1'b1;
      rsp_ack <= 1'b1;
      rsp_arb <= (nrsp == arb_n);
      nrsp++;
      case (req_op)
        3'd0: first_w = 1;
        3'd1: begin
          rsp_ack <= first_w ? (req_data[7:1] == TGT) : 1'b1;
          first_w = 0;
        end
        3'd2, 3'd3: begin
          rsp_data <= (cnt_mode && rdk == 0) ? blk_cnt : rd_base + 8'(rdk);
          rdk++;
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic clr_log();
    @(negedge clk); nlog = 0; nexp = 0; nrsp = 0; rdk = 0;
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] d);
    eop[nexp] = op; edat[nexp] = d; nexp++;
  endtask

  task automatic cmp_log(input string tag);
    int bad = 0;
    if (nlog != nexp) bad = 1;
    else for (int i = 0; i < nexp; i++)
      if (lop[i] != eop[i] || (eop[i] == 3'd1 && ldat[i] != edat[i])) bad = 1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: request log of %0d entries, expected %0d entries", tag, nlog, nexp);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  function automatic int clampb(input int v);
    return v < 1 ? 1 : (v > 32 ? 32 : v);
  endfunction

  task automatic blk_write(input int cnt, input bit i2c);
    logic [7:0] s;
    int n = clampb(cnt), pauses = 0, busy_ok = 1;
    clr_log(); i2c_mode = i2c;
    wr(3'd4, {TGT, 1'b0}); wr(3'd3, 8'h5A); wr(3'd5, 8'(cnt)); wr(3'd7, 8'hC0);
    wr(3'd2, 8'h54);
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, s);
      if (s[7]) begin
        if (!s[0]) busy_ok = 0;
        pauses++;
        wr(3'd7, 8'hC0 + 8'(pauses));
        wr(3'd0, 8'h80);
      end else if (!s[0]) break;
    end
    ex(0, 0); ex(1, {TGT, 1'b0}); ex(1, 8'h5A);
    if (!i2c) ex(1, 8'(n));
    for (int k = 0; k < n; k++) ex(1, 8'hC0 + 8'(k));
    ex(4, 0);
    cmp_log(i2c ? "R7 i2c-style block write sequence" : "R5 block write sequence");
    chk("R5 pauses before final byte", pauses, n - 1);
    chk("R5 busy held during pauses", busy_ok, 1);
    rd(3'd5, s); chk("R5 clamped count in data0", s, n);
    rd(3'd0, s); chk("R5 done after block write", s, 8'h02);
    wr(3'd0, 8'hFF); i2c_mode = 0;
  endtask

  task automatic blk_read(input int cnt);
    logic [7:0] s, b;
    int n = clampb(cnt), got = 0, bad = 0;
    clr_log(); cnt_mode = 1; blk_cnt = 8'(cnt); rd_base = 8'h50;
    wr(3'd4, {TGT, 1'b1}); wr(3'd3, 8'h6B); wr(3'd2, 8'h54);
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, s);
      if (s[7]) begin
        rd(3'd7, b);
        if (b != rd_base + 8'(1 + got)) bad = 1;
        got++;
        wr(3'd0, 8'h80);
      end else if (!s[0]) break;
    end
    rd(3'd7, b);
    if (b != rd_base + 8'(1 + got)) bad = 1;
    got++;
    ex(0, 0); ex(1, {TGT, 1'b0}); ex(1, 8'h6B); ex(0, 0); ex(1, {TGT, 1'b1}); ex(2, 0);
    for (int k = 0; k < n; k++) ex(k == n - 1 ? 3'd3 : 3'd2, 0);
    ex(4, 0);
    cmp_log("R6 block read sequence with final NACK");
    chk("R6 received bytes match", bad, 0);
    chk("R6 bytes delivered", got, n);
    rd(3'd5, s); chk("R6 clamped count in data0", s, n);
    cnt_mode = 0; wr(3'd0, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] s, v;
    string tag;
    int allz;
    repeat (3) @(negedge clk);
    rst_n = 1;
    allz = 0;
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); allz |= int'(v); end
    chk("R1 registers zero after reset", allz, 0);
    chk("R1 irq low after reset", irq, 0);
    chk("R1 no request after reset", nlog, 0);

    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < 2; r++) begin
        tag = (t == 0) ? "R2" : (t == 1) ? "R3" : "R4";
        clr_log(); rd_base = 8'h80 + 8'(16 * t);
        wr(3'd4, {TGT, 1'(r)}); wr(3'd3, 8'h40 + 8'(t));
        wr(3'd5, 8'h11 * 8'(t + 1)); wr(3'd6, 8'h0F + 8'(t));
        wr(3'd2, 8'h41 | 8'(t << 2));
        wait_idle();
        ex(0, 0);
        if (t == 0) ex(1, {TGT, 1'(r)});
        else if (t == 1) begin
          ex(1, {TGT, 1'(r)});
          if (r) ex(3, 0); else ex(1, 8'h40 + 8'(t));
        end else begin
          ex(1, {TGT, 1'b0}); ex(1, 8'h40 + 8'(t));
          if (r) begin
            ex(0, 0); ex(1, {TGT, 1'b1});
            if (t == 3) ex(2, 0);
            ex(3, 0);
          end else begin
            ex(1, 8'h11 * 8'(t + 1));
            if (t == 3) ex(1, 8'h0F + 8'(t));
          end
        end
        ex(4, 0);
        cmp_log({tag, " request sequence"});
        rd(3'd0, s); chk({tag, " status done only"}, s, 8'h02);
        chk("R12 irq with enable set", irq, 1);
        if (r && t > 0) begin
          rd(3'd5, v); chk({tag, " read byte in data0"}, v, rd_base);
          if (t == 3) begin rd(3'd6, v); chk("R4 word high byte in data1", v, rd_base + 1); end
        end
        wr(3'd0, s); rd(3'd0, v); chk("R11 write-back clears status", v, 0);
      end
    end

    clr_log(); wr(3'd4, {TGT, 1'b0}); wr(3'd2, 8'h40); wait_idle();
    rd(3'd0, s); chk("R12 status done with enable clear", s, 8'h02);
    chk("R12 irq low with enable clear", irq, 0);
    wr(3'd0, 8'hFF);

    blk_write(0, 0); blk_write(1, 0); blk_write(2, 0);
    blk_write(5, 0); blk_write(32, 0); blk_write(40, 0);
    blk_write(3, 1);
    blk_read(0); blk_read(1); blk_read(4); blk_read(50);

    clr_log(); wr(3'd4, {7'h11, 1'b0}); wr(3'd3, 8'h22); wr(3'd2, 8'h45); wait_idle();
    ex(0, 0); ex(1, {7'h11, 1'b0}); ex(4, 0);
    cmp_log("R8 address NACK ends with STOP");
    rd(3'd0, s); chk("R8 device error flag only", s, 8'h04);
    chk("R8 no irq on error", irq, 0);
    clr_log(); wr(3'd4, {TGT, 1'b0}); wr(3'd2, 8'h40); repeat (4) @(negedge clk);
    chk("R10 start over stale status issues nothing", nlog, 0);
    rd(3'd0, s); chk("R10 failed flag added", s, 8'h14);
    wr(3'd0, s); rd(3'd0, v); chk("R11 write-back clears error flags", v, 0);

    clr_log(); wr(3'd2, 8'h50); repeat (4) @(negedge clk);
    chk("R10 unsupported code issues nothing", nlog, 0);
    rd(3'd0, s); chk("R10 unsupported code sets failed", s, 8'h10);
    wr(3'd0, 8'hFF);

    clr_log(); host_en = 0; wr(3'd2, 8'h40); repeat (4) @(negedge clk);
    chk("R10 disabled host issues nothing", nlog, 0);
    rd(3'd0, s); chk("R10 disabled host leaves status", s, 0);
    host_en = 1;

    clr_log(); arb_n = 1;
    wr(3'd4, {TGT, 1'b0}); wr(3'd3, 8'h33); wr(3'd5, 8'h44); wr(3'd2, 8'h48);
    wait_idle(); repeat (4) @(negedge clk);
    chk("R9 no request after arbitration loss", nlog, 2);
    rd(3'd0, s); chk("R9 collision flag only", s, 8'h08);
    arb_n = -1; wr(3'd0, 8'hFF);

    wr(3'd2, 8'h35); rd(3'd2, v); chk("R11 control readback", v, 8'h35);
    rd(3'd0, s); chk("R11 control write without start keeps idle", s, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule